// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block drives the control and data pins of a NAND flash device for command bytes, address bytes and single-byte data transfers. Requests enter an eight-deep queue. Each request has a kind, a byte value and an optional "wait for ready" flag. The sequencer pops the requests one at a time and plays out the matching pin waveform. It then raises a one-clock completion pulse.

All timing is counted in quarter bus cycles, with one quarter per clock of `clk`. A bus cycle is therefore four clocks. Command and address cycles follow one of two timing sets, chosen by `extMode`:

- The normal set uses short setup and hold windows.
- The extended set uses longer ones.

Data write and data read cycles always take one bus cycle and use half-cycle strobes, whatever the mode. After a command byte that carries the wait flag, the sequencer holds off its completion pulse until the ready/busy line reports ready.

Top module: `nand_cmd_seq`

## Requirements
- R1: While and after reset, with nothing queued: `nandCle`=0, `nandAle`=0, `nandWeN`=1, `nandReN`=1, `nandDqOe`=0, `nandDqOut`=0, `entryDone`=0, `rdValid`=0 and `pushReady`=1.
- R2: A command entry (kind 2'b00) with normal timing lasts 12 clocks, numbered 0 to 11:
  - `nandCle` is high on clocks 0 to 11.
  - `nandWeN` is low on clocks 4 to 7.
  - `nandDqOe` is high and `nandDqOut` carries the byte on clocks 4 to 11.
  - `nandAle` stays low.
- R3: A command entry with extended timing lasts 24 clocks:
  - `nandCle` is high on clocks 0 to 23.
  - `nandWeN` is low on clocks 8 to 15.
  - The byte is driven on clocks 4 to 19.
- R4: An address entry (kind 2'b01) has the timing of R2 or R3, chosen by mode, but drives `nandAle` in place of `nandCle`; `nandCle` stays low.
- R5: A data write entry (kind 2'b10) lasts 4 clocks in both modes:
  - `nandWeN` is low on clocks 1 and 2.
  - The byte is driven on all four clocks.
  - `nandCle` and `nandAle` stay low.
- R6: A data read entry (kind 2'b11) lasts 4 clocks in both modes:
  - `nandReN` is low on clocks 0 and 1.
  - The data bus is not driven.
  - `nandDqIn` is captured into `rdByte` while `nandReN` is still low; `rdValid` is high on clock 1 only, with `rdByte` already updated.
- R7: The queue holds 8 entries. `pushReady` is low exactly when 8 are held, and a push while full is dropped without disturbing the queued entries.
- R8: Entries run in push order. When the sequencer is idle, clock 0 of a pushed entry appears on the outputs two clocks after the push edge. A queued entry's clock 0 follows the previous entry's last clock directly.
- R9: A command entry with the wait flag withholds `entryDone` after its last clock until `nandRbN` is high. The pulse then appears on the third clock after `nandRbN` rises. The wait flag is ignored on every other kind.
- R10: The timing set is taken from `extMode` when an entry starts; changing `extMode` during the entry does not alter that entry.
- R11: `entryDone` is high for exactly one clock: the entry's last clock, or the clock given by R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| extMode | input | 1 | 1 selects extended command/address timing |
| pushValid | input | 1 | Push a request this clock |
| pushKind | input | 2 | 00 command, 01 address, 10 data write, 11 data read |
| pushWaitRb | input | 1 | Wait for ready after this command |
| pushValue | input | 8 | Byte to send |
| pushReady | output | 1 | Queue has room |
| nandRbN | input | 1 | Ready/busy, high when ready |
| nandDqIn | input | 8 | Data bus from the device |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandDqOut | output | 8 | Data bus to the device |
| nandDqOe | output | 1 | Data bus drive enable |
| rdValid | output | 1 | `rdByte` was just captured |
| rdByte | output | 8 | Last captured read byte |
| entryDone | output | 1 | Entry completion pulse |

## Verification
Pins and completion flags are due two clocks after a push edge on an idle sequencer; clock 0 of the entry shows up there.

The bench therefore waits one clock after the push before sampling. It then compares every following clock at the falling edge with the waveform formed from the R2 to R6 windows, one entry clock per sample, through to the idle clock after the last one.

For the ready wait, the bench counts falling edges from the rise of `nandRbN` and expects the pulse on the third. In the back-to-back run, the bench expects successive write-enable rises exactly 12 clocks apart.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'b00,
    KIND_ADDR  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_READ  = 2'b11
  } entryKind_e;

  typedef struct packed {
    entryKind_e        kind;
    logic              waitRb;
    logic [BYTE_W-1:0] value;
  } entry_t;

  // strobes from the control to the datapath, one clock ahead of the pins
  typedef struct packed {
    logic load;
    logic latchCmd;
    logic latchAddr;
    logic weLow;
    logic reLow;
    logic dqDrive;
    logic capture;
    logic done;
  } strobes_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int PHASES       = 4,
  parameter int CMD_SETUP_N  = 8,
  parameter int CMD_SETUP_X  = 16,
  parameter int CMD_HOLD_N   = 4,
  parameter int CMD_HOLD_X   = 8,
  parameter int WE_LOW_N     = 4,
  parameter int WE_LOW_X     = 8,
  parameter int WE_HIGH_N    = 4,
  parameter int WE_HIGH_X    = 8,
  parameter int DATA_SETUP_N = 4,
  parameter int DATA_SETUP_X = 12,
  parameter int DATA_HOLD    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extMode,
  input  logic       rbReady,
  input  logic       qEmpty,
  input  entryKind_e headKind,
  input  logic       headWaitRb,
  output strobes_t   strobes
);

  localparam int TOTAL_N = CMD_SETUP_N + maxOf3(CMD_HOLD_N, WE_HIGH_N, DATA_HOLD);
  localparam int TOTAL_X = CMD_SETUP_X + maxOf3(CMD_HOLD_X, WE_HIGH_X, DATA_HOLD);
  localparam int PW      = $clog2(TOTAL_X + PHASES + 1);
  localparam logic [PW-1:0] FAST_LAST   = PW'(PHASES - 1);
  localparam logic [PW-1:0] FAST_WE_LO  = PW'(PHASES / 4);
  localparam logic [PW-1:0] FAST_WE_HI  = PW'((3 * PHASES) / 4);
  localparam logic [PW-1:0] FAST_RE_END = PW'(PHASES / 2);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAITRB} seqState_e;

  seqState_e  state;
  logic [PW-1:0] phase;
  entryKind_e curKind;
  logic       curWait, curExt;
  logic       rbMeta, rbSync;

  logic [PW-1:0] setupQ, weLowQ, latchEndQ, dataStartQ, dataEndQ, totalQ;
  logic isSlow, lastPhase, waitCmd, endOfEntry, rbDone, finish;

  always_comb begin
    setupQ     = curExt ? PW'(CMD_SETUP_X) : PW'(CMD_SETUP_N);
    weLowQ     = curExt ? PW'(WE_LOW_X)    : PW'(WE_LOW_N);
    latchEndQ  = setupQ + (curExt ? PW'(CMD_HOLD_X) : PW'(CMD_HOLD_N));
    dataStartQ = setupQ - (curExt ? PW'(DATA_SETUP_X) : PW'(DATA_SETUP_N));
    dataEndQ   = setupQ + PW'(DATA_HOLD);
    totalQ     = curExt ? PW'(TOTAL_X) : PW'(TOTAL_N);
    isSlow     = (curKind == KIND_CMD) || (curKind == KIND_ADDR);
    lastPhase  = isSlow ? (phase == totalQ - PW'(1)) : (phase == FAST_LAST);
    waitCmd    = curWait && (curKind == KIND_CMD);
    endOfEntry = (state == ST_RUN) && lastPhase && !waitCmd;
    rbDone     = (state == ST_WAITRB) && rbSync;
    finish     = endOfEntry || rbDone;

    strobes      = '0;
    strobes.done = finish;
    strobes.load = ((state == ST_IDLE) || finish) && !qEmpty;
    if (state == ST_RUN) begin
      if (isSlow) begin
        strobes.latchCmd  = (curKind == KIND_CMD)  && (phase < latchEndQ);
        strobes.latchAddr = (curKind == KIND_ADDR) && (phase < latchEndQ);
        strobes.weLow     = (phase >= setupQ - weLowQ) && (phase < setupQ);
        strobes.dqDrive   = (phase >= dataStartQ) && (phase < dataEndQ);
      end else if (curKind == KIND_WRITE) begin
        strobes.weLow   = (phase >= FAST_WE_LO) && (phase < FAST_WE_HI);
        strobes.dqDrive = 1'b1;
      end else begin
        strobes.reLow   = (phase < FAST_RE_END);
        strobes.capture = (phase == FAST_RE_END - PW'(1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= '0;
      curKind <= KIND_CMD;
      curWait <= 1'b0;
      curExt  <= 1'b0;
      rbMeta  <= 1'b0;
      rbSync  <= 1'b0;
    end else begin
      rbMeta <= rbReady;
      rbSync <= rbMeta;
      if (strobes.load) begin
        state   <= ST_RUN;
        phase   <= '0;
        curKind <= headKind;
        curWait <= headWaitRb;
        curExt  <= extMode;
      end else if (state == ST_RUN) begin
        if (lastPhase) begin
          state <= waitCmd ? ST_WAITRB : ST_IDLE;
          phase <= '0;
        end else begin
          phase <= phase + PW'(1);
        end
      end else if (rbDone) begin
        state <= ST_IDLE;
      end
    end
  end

  // R10: timing set is frozen for the life of an entry
  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && phase != '0) |-> $stable(curExt));

  // R9: only a flagged command byte can park in the ready wait
  p_wait_only_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITRB) |-> (curKind == KIND_CMD && curWait));

endmodule

// File: rtl/nand_seq_datapath.sv
module nand_seq_datapath
  import nand_seq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  entry_t            pushEntry,
  output logic              pushReady,
  output logic              qEmpty,
  output entryKind_e        headKind,
  output logic              headWaitRb,
  input  strobes_t          strobes,
  input  logic [BYTE_W-1:0] dqIn,
  output logic              cle,
  output logic              ale,
  output logic              weN,
  output logic              reN,
  output logic [BYTE_W-1:0] dqOut,
  output logic              dqOe,
  output logic              rdValid,
  output logic [BYTE_W-1:0] rdByte,
  output logic              done
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  entry_t            mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [BYTE_W-1:0] curValue;
  logic              pushOk, pop;

  assign pushReady  = (count != FULL_CNT);
  assign qEmpty     = (count == '0);
  assign pushOk     = pushValid && pushReady;
  assign pop        = strobes.load;
  assign headKind   = mem[rdPtr].kind;
  assign headWaitRb = mem[rdPtr].waitRb;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      curValue <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (pop) begin
        rdPtr    <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
        curValue <= mem[rdPtr].value;
      end
      count <= count + CNT_W'(pushOk) - CNT_W'(pop);
    end
  end

  // pin registers: every pin follows its strobe by one clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cle     <= 1'b0;
      ale     <= 1'b0;
      weN     <= 1'b1;
      reN     <= 1'b1;
      dqOe    <= 1'b0;
      dqOut   <= '0;
      rdValid <= 1'b0;
      rdByte  <= '0;
      done    <= 1'b0;
    end else begin
      cle     <= strobes.latchCmd;
      ale     <= strobes.latchAddr;
      weN     <= !strobes.weLow;
      reN     <= !strobes.reLow;
      dqOe    <= strobes.dqDrive;
      dqOut   <= strobes.dqDrive ? curValue : '0;
      rdValid <= strobes.capture;
      if (strobes.capture) rdByte <= dqIn;
      done    <= strobes.done;
    end
  end

  // R7: a full queue with no pop stays full, whatever is pushed
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL_CNT && !pop) |=> (count == FULL_CNT));

  // R8: the control never pops an empty queue
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));

  // R5: write and read strobes never overlap on the pins
  p_we_re_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));

  // R4: at most one latch enable at a time
  p_one_latch_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));

  // R2: the byte is on the bus at every write-enable rise
  p_dq_at_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> dqOe);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extMode,
  input  logic       pushValid,
  input  logic [1:0] pushKind,
  input  logic       pushWaitRb,
  input  logic [7:0] pushValue,
  output logic       pushReady,
  input  logic       nandRbN,
  input  logic [7:0] nandDqIn,
  output logic       nandCle,
  output logic       nandAle,
  output logic       nandWeN,
  output logic       nandReN,
  output logic [7:0] nandDqOut,
  output logic       nandDqOe,
  output logic       rdValid,
  output logic [7:0] rdByte,
  output logic       entryDone
);

  entry_t     pushEntry;
  strobes_t   strobes;
  logic       qEmpty, headWaitRb;
  entryKind_e headKind;

  assign pushEntry = '{kind: entryKind_e'(pushKind), waitRb: pushWaitRb, value: pushValue};

  nand_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .extMode(extMode), .rbReady(nandRbN),
    .qEmpty(qEmpty), .headKind(headKind), .headWaitRb(headWaitRb),
    .strobes(strobes)
  );

  nand_seq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushEntry(pushEntry),
    .pushReady(pushReady), .qEmpty(qEmpty), .headKind(headKind),
    .headWaitRb(headWaitRb), .strobes(strobes), .dqIn(nandDqIn),
    .cle(nandCle), .ale(nandAle), .weN(nandWeN), .reN(nandReN),
    .dqOut(nandDqOut), .dqOe(nandDqOe), .rdValid(rdValid),
    .rdByte(rdByte), .done(entryDone)
  );

endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extMode = 1'b0, pushValid = 1'b0, pushWaitRb = 1'b0;
  logic [1:0] pushKind = 2'b00;
  logic [7:0] pushValue = 8'h00, nandDqIn = 8'h00;
  logic nandRbN = 1'b1;
  logic pushReady, nandCle, nandAle, nandWeN, nandReN, nandDqOe, rdValid, entryDone;
  logic [7:0] nandDqOut, rdByte;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nand_cmd_seq u_dut (.*);

  // vector: {kind[1:0], ext, value[7:0]}
  localparam logic [10:0] VEC [8] = '{
    {2'b00, 1'b0, 8'h70}, {2'b00, 1'b1, 8'h90},
    {2'b01, 1'b0, 8'h00}, {2'b01, 1'b1, 8'hA5},
    {2'b10, 1'b0, 8'h3C}, {2'b10, 1'b1, 8'hC3},
    {2'b11, 1'b0, 8'h5A}, {2'b11, 1'b1, 8'h81}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [1:0] k, input logic ext);
    case (k)
      2'b00:   return ext ? "R3" : "R2";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // expected {cle, ale, weN, reN, dqOe, done, rdValid, dq-or-rdByte}
  function automatic logic [14:0] expWave(input logic [1:0] k, input logic ext,
                                          input logic [7:0] v, input int p, input int total);
    int s, h, l, ds;
    logic c, a, we, re, oe, dn, rv;
    logic [7:0] d;
    c = 0; a = 0; we = 1; re = 1; oe = 0; rv = 0; d = 8'h00;
    dn = (p == total - 1);
    if (p >= total) return {7'b0011000, 8'h00};
    if (!k[1]) begin
      s = ext ? 16 : 8; l = ext ? 8 : 4; h = ext ? 8 : 4; ds = ext ? 12 : 4;
      c  = (k == 2'b00) && (p < s + h);
      a  = (k == 2'b01) && (p < s + h);
      we = !((p >= s - l) && (p < s));
      oe = (p >= s - ds) && (p < s + 4);
      d  = oe ? v : 8'h00;
    end else if (k == 2'b10) begin
      we = !(p == 1 || p == 2);
      oe = 1; d = v;
    end else begin
      re = !(p < 2);
      rv = (p == 1);
      d  = rv ? ~v : 8'h00;
    end
    return {c, a, we, re, oe, dn, rv, d};
  endfunction

  task automatic pushOne(input logic [1:0] k, input logic wt, input logic [7:0] v);
    pushValid = 1; pushKind = k; pushWaitRb = wt; pushValue = v;
    @(negedge clk);
    pushValid = 0;
  endtask

  task automatic runEntry(input logic [1:0] k, input logic ext, input logic [7:0] v,
                          input logic wt, input logic flip, input string req);
    int total;
    bit bad;
    int badP;
    logic [14:0] act, exp, badAct, badExp;
    total = k[1] ? 4 : (ext ? 24 : 12);
    extMode = ext;
    nandDqIn = ~v;
    bad = 0; badP = 0; badAct = '0; badExp = '0;
    pushOne(k, wt, v);
    @(negedge clk);
    for (int p = 0; p <= total; p++) begin
      @(negedge clk);
      if (flip && p == 0) extMode = ~ext;
      exp = expWave(k, ext, v, p, total);
      act = {nandCle, nandAle, nandWeN, nandReN, nandDqOe, entryDone, rdValid,
             rdValid ? rdByte : nandDqOut};
      if (act !== exp && !bad) begin
        bad = 1; badP = p; badAct = act; badExp = exp;
      end
    end
    check(!bad, req, $sformatf("waveform kind=%0d ext=%0d clock=%0d", k, ext, badP),
          32'(badAct), 32'(badExp));
  endtask

  // monitor for the back-to-back run
  bit monOn = 0;
  int cyc = 0, nRise = 0, nDone = 0;
  logic prevWe = 1'b1;
  logic [7:0] riseByte [16];
  int riseTime [16];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!monOn) begin
      nRise = 0; nDone = 0; prevWe = 1'b1;
    end else begin
      if (!prevWe && nandWeN && nRise < 16) begin
        riseByte[nRise] = nandDqOut;
        riseTime[nRise] = cyc;
        nRise++;
      end
      prevWe = nandWeN;
      if (entryDone) nDone++;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat, gotRise, gotDone;
    bit seen, orderOk, gapOk;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({nandCle, nandAle, nandWeN, nandReN, nandDqOe, entryDone, rdValid, pushReady, nandDqOut} == {8'b00110001, 8'h00},
          "R1", "reset levels in reset",
          32'({nandCle, nandAle, nandWeN, nandReN, nandDqOe, entryDone, rdValid, pushReady, nandDqOut}), 32'h3100);
    rstN = 1;
    @(negedge clk);
    check({nandCle, nandAle, nandWeN, nandReN, nandDqOe, entryDone, rdValid, pushReady, nandDqOut} == {8'b00110001, 8'h00},
          "R1", "idle levels after reset",
          32'({nandCle, nandAle, nandWeN, nandReN, nandDqOe, entryDone, rdValid, pushReady, nandDqOut}), 32'h3100);

    // table walk: R2 R3 R4 R5 R6, each with R8 start latency and R11 done
    for (int i = 0; i < 8; i++) begin
      runEntry(VEC[i][10:9], VEC[i][8], VEC[i][7:0], 1'b0, 1'b0, reqOf(VEC[i][10:9], VEC[i][8]));
      @(negedge clk);
    end

    // R10: mode flipped during an entry keeps the timing it started with
    runEntry(2'b00, 1'b0, 8'hE0, 1'b0, 1'b1, "R10");
    runEntry(2'b01, 1'b1, 8'h3E, 1'b0, 1'b1, "R10");
    extMode = 0;
    @(negedge clk);

    // R9: command with wait flag holds done until ready
    nandRbN = 0;
    repeat (3) @(negedge clk);
    pushOne(2'b00, 1'b1, 8'hFF);
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (entryDone) seen = 1;
    end
    check(!seen, "R9", "done while busy", 32'(seen), 32'd0);
    nandRbN = 1;
    lat = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (entryDone && lat == 0) lat = k;
    end
    check(lat == 3, "R9", "done latency after ready", 32'(lat), 32'd3);

    // R9: wait flag on an address entry is ignored
    nandRbN = 0;
    repeat (3) @(negedge clk);
    runEntry(2'b01, 1'b0, 8'h12, 1'b1, 1'b0, "R9");
    nandRbN = 1;
    repeat (3) @(negedge clk);

    // R7 / R8: fill the queue and run back to back
    monOn = 1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      pushValid = 1; pushKind = 2'b00; pushWaitRb = 0; pushValue = 8'(i);
      if (i == 8) check(pushReady == 1, "R7", "ready with 7 queued", 32'(pushReady), 32'd1);
      if (i == 9) check(pushReady == 0, "R7", "ready with 8 queued", 32'(pushReady), 32'd0);
      @(negedge clk);
    end
    pushValid = 0;
    repeat (130) @(negedge clk);
    @(posedge clk);
    gotRise = nRise; gotDone = nDone;
    orderOk = 1; gapOk = 1;
    for (int i = 0; i < 9 && i < gotRise; i++) begin
      if (riseByte[i] != 8'(i)) orderOk = 0;
      if (i > 0 && riseTime[i] - riseTime[i-1] != 12) gapOk = 0;
    end
    monOn = 0;
    check(gotRise == 9 && gotDone == 9, "R7", "entries run after overfill",
          32'({gotRise[15:0], gotDone[15:0]}), 32'h0009_0009);
    check(orderOk, "R8", "byte order at write-enable rises", 32'(orderOk), 32'd1);
    check(gapOk, "R8", "back-to-back spacing of 12 clocks", 32'(gapOk), 32'd1);
    @(negedge clk);
    check(pushReady && nandWeN && !nandCle && !entryDone, "R1", "idle after drain",
          32'({pushReady, nandWeN, nandCle, entryDone}), 32'b1100);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule